// File: doc/BRIEF.md
# Crosspoint Matrix Configuration Controller

This block is the digital control plane of a 32-output by 32-input nonblocking switch matrix. Every output owns a 6-bit configuration entry that names one input and says whether the output drives at all. Entries are written into a staging rank, either one bit per clock through a long shift chain or one whole entry per clock at an address. A separate transfer strobe then copies the staging rank into a live rank. Only the live rank steers the matrix, so a full new routing can be prepared without disturbing the traffic that is flowing.

The live rank is decoded into 1024 crosspoint enables, 32 per output, with at most one high in each group, and into one drive enable per output. The far end of the shift chain is brought out on a pin, so several controllers can be chained and loaded from one serial source. An asynchronous active-low reset turns every output off. The block has no back-pressure: there is no ready signal, and the block accepts every qualified write strobe in the same cycle it is presented. A source must therefore pace itself only by the clock.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: While `rst_n` is low, both ranks clear at once without a clock edge. `out_en`, `xpt_sel` and `ser_out` read all zero, and they stay zero after release until new entries are loaded and transferred.
- R2: A live entry holds an input index in bits [4:0] and a drive-enable flag in bit 5. `out_en[o]` equals bit 5 of output o's live entry.
- R3: `xpt_sel[o*32+i]` is high only when output o is enabled and its index equals i. Each 32-bit group is therefore one-hot when enabled and all zero when disabled.
- R4: With `ser_mode`=1 and `wr_en`=1, each rising edge shifts `ser_in` into the chain. After 192 shifts, the first bit sent is the MSB of output 31's entry, and the last six bits sent form output 0's entry, MSB first.
- R5: `ser_out` shows the bit at the far end of the chain. During a further 192 shifts it replays the earlier stream, first bit first.
- R6: With `wr_en`=0 the staging rank and `ser_out` keep their values, whatever the data, address and serial lines do.
- R7: With `ser_mode`=0 and `wr_en`=1, a rising edge writes `par_data` into the entry selected by `par_addr` and leaves every other entry unchanged.
- R8: While `upd_n` is high, `out_en` and `xpt_sel` do not change, even while the staging rank is rewritten.
- R9: At each rising edge where `upd_n` is low, the live rank takes the staging rank as it stood before that edge. Held low, the live rank follows the staging rank one cycle behind.
- R10: In parallel mode `ser_in` has no effect. In serial mode `par_addr` and `par_data` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all loads and transfers |
| rst_n | input | 1 | Asynchronous active-low reset; turns every output off |
| ser_mode | input | 1 | 1 = shift-chain loading, 0 = addressed entry writes |
| wr_en | input | 1 | Qualifies a shift or an entry write on this edge |
| ser_in | input | 1 | Serial configuration bit entering the chain |
| par_addr | input | 5 | Output number whose entry a parallel write replaces |
| par_data | input | 6 | Entry for a parallel write: enable in bit 5, index in [4:0] |
| upd_n | input | 1 | Active-low transfer of the staging rank into the live rank |
| ser_out | output | 1 | Far end of the shift chain, for cascading |
| xpt_sel | output | 1024 | One-hot crosspoint enables, 32 per output |
| out_en | output | 32 | Drive enable per output |

## Verification
On every cycle the assertions check that each output's select group is one-hot or empty and agrees with its drive enable. They also check that the live outputs stay frozen while the transfer strobe is inactive, that the chain's far end holds when no write is qualified, and that everything reads zero on the first edge after reset. The bench scenarios show the rest. These are the bit ordering of a full serial load, the replay of the stream on the chain output, the isolation of one addressed write from its neighbours, the one-cycle lag of a held transfer strobe, and the immediate effect of an asynchronous reset between clock edges.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  // Loading style chosen by the mode pin.
  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;

  localparam int DEF_N_OUT = 32;
  localparam int DEF_N_IN  = 32;
endpackage

// File: rtl/xpt_stage_rank.sv
// First configuration rank: a shift chain that also accepts addressed writes.
module xpt_stage_rank
  import xpt_pkg::*;
#(
  parameter int N_OUT  = DEF_N_OUT,
  parameter int ENT_W  = 6,
  parameter int ADDR_W = 5,
  localparam int CHAIN_W = N_OUT * ENT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_mode,
  input  logic               wr_en,
  input  logic               ser_in,
  input  logic [ADDR_W-1:0]  par_addr,
  input  logic [ENT_W-1:0]   par_data,
  output logic [CHAIN_W-1:0] stage_q,
  output logic               ser_out
);
  logic [CHAIN_W-1:0] chain_q, chain_nxt;
  load_mode_e         mode;

  assign mode = load_mode_e'(ser_mode);

  always_comb begin
    chain_nxt = chain_q;
    if (wr_en) begin
      if (mode == LOAD_SER) begin
        // New bits enter at the low end; the entry for output 0 sits there.
        chain_nxt = {chain_q[CHAIN_W-2:0], ser_in};
      end else begin
        for (int e = 0; e < N_OUT; e++) begin
          if (par_addr == ADDR_W'(e)) begin
            chain_nxt[e*ENT_W +: ENT_W] = par_data;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign stage_q = chain_q;
  assign ser_out = chain_q[CHAIN_W-1];
endmodule

// File: rtl/xpt_hold_rank.sv
// Second configuration rank: the only state that steers the matrix.
module xpt_hold_rank #(
  parameter int CHAIN_W = 192
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_n,
  input  logic [CHAIN_W-1:0] stage_d,
  output logic [CHAIN_W-1:0] live_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      live_q <= '0;
    else if (!upd_n) live_q <= stage_d;
  end
endmodule

// File: rtl/xpt_decode.sv
// Turns every live entry into a one-hot select group plus a drive enable.
module xpt_decode #(
  parameter int N_OUT = 32,
  parameter int N_IN  = 32,
  parameter int IDX_W = 5,
  localparam int ENT_W   = IDX_W + 1,
  localparam int CHAIN_W = N_OUT * ENT_W
) (
  input  logic [CHAIN_W-1:0]    live,
  output logic [N_OUT*N_IN-1:0] sel,
  output logic [N_OUT-1:0]      out_en
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [IDX_W-1:0] idx;
    logic             en_bit;
    logic             valid;

    assign idx    = live[o*ENT_W +: IDX_W];
    assign en_bit = live[o*ENT_W + IDX_W];
    // An index beyond the input count cannot drive anything.
    assign valid  = en_bit && (int'(idx) < N_IN);
    assign out_en[o] = valid;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign sel[o*N_IN + i] = valid && (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
  import xpt_pkg::*;
#(
  parameter int N_OUT = DEF_N_OUT,
  parameter int N_IN  = DEF_N_IN,
  localparam int IDX_W   = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  localparam int ADDR_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int ENT_W   = IDX_W + 1,
  localparam int CHAIN_W = N_OUT * ENT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_mode,
  input  logic                    wr_en,
  input  logic                    ser_in,
  input  logic [ADDR_W-1:0]       par_addr,
  input  logic [ENT_W-1:0]        par_data,
  input  logic                    upd_n,
  output logic                    ser_out,
  output logic [N_OUT*N_IN-1:0]   xpt_sel,
  output logic [N_OUT-1:0]        out_en
);
  logic [CHAIN_W-1:0] stage_w;
  logic [CHAIN_W-1:0] live_w;

  xpt_stage_rank #(
    .N_OUT (N_OUT),
    .ENT_W (ENT_W),
    .ADDR_W(ADDR_W)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_mode(ser_mode),
    .wr_en   (wr_en),
    .ser_in  (ser_in),
    .par_addr(par_addr),
    .par_data(par_data),
    .stage_q (stage_w),
    .ser_out (ser_out)
  );

  xpt_hold_rank #(
    .CHAIN_W(CHAIN_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_n  (upd_n),
    .stage_d(stage_w),
    .live_q (live_w)
  );

  xpt_decode #(
    .N_OUT(N_OUT),
    .N_IN (N_IN),
    .IDX_W(IDX_W)
  ) u_dec (
    .live  (live_w),
    .sel   (xpt_sel),
    .out_en(out_en)
  );
endmodule

// File: rtl/xpt_cfg_ctrl_chk.sv
module xpt_cfg_ctrl_chk #(
  parameter int N_OUT = 32,
  parameter int N_IN  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  upd_n,
  input logic                  ser_out,
  input logic [N_OUT*N_IN-1:0] xpt_sel,
  input logic [N_OUT-1:0]      out_en
);
  // R1: first edge after release still sees everything off.
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_en == '0 && xpt_sel == '0 && !ser_out));

  // R8: outputs frozen while no transfer is requested.
  p_hold_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_n |=> ($stable(out_en) && $stable(xpt_sel)));

  // R6: chain far end holds without a qualified write.
  p_ser_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ser_out));

  for (genvar o = 0; o < N_OUT; o++) begin : g_grp
    // R3: at most one crosspoint per output.
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xpt_sel[o*N_IN +: N_IN]));
    // R2: drive enable agrees with the select group.
    p_en_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_en[o] == (|xpt_sel[o*N_IN +: N_IN]));
  end
endmodule

bind xpt_cfg_ctrl xpt_cfg_ctrl_chk #(
  .N_OUT(N_OUT),
  .N_IN (N_IN)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .upd_n  (upd_n),
  .ser_out(ser_out),
  .xpt_sel(xpt_sel),
  .out_en (out_en)
);

// File: tb/xpt_cfg_ctrl_tb.sv
`timescale 1ns/1ps
module xpt_cfg_ctrl_tb;
  localparam int NO = 32;
  localparam int NI = 32;
  localparam int CW = NO * 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_mode = 1'b0;
  logic wr_en = 1'b0;
  logic ser_in = 1'b0;
  logic [4:0] par_addr = '0;
  logic [5:0] par_data = '0;
  logic upd_n = 1'b1;
  logic ser_out;
  logic [NO*NI-1:0] xpt_sel;
  logic [NO-1:0] out_en;

  int checks = 0;
  int failures = 0;

  logic [CW-1:0] m_stage = '0;
  logic [CW-1:0] m_live = '0;

  always #2 clk = ~clk;

  xpt_cfg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .wr_en(wr_en),
    .ser_in(ser_in), .par_addr(par_addr), .par_data(par_data),
    .upd_n(upd_n), .ser_out(ser_out), .xpt_sel(xpt_sel), .out_en(out_en)
  );

  function automatic logic [NO*NI-1:0] exp_sel(input logic [CW-1:0] lv);
    logic [NO*NI-1:0] r = '0;
    for (int o = 0; o < NO; o++)
      if (lv[o*6+5]) r[o*NI + int'(lv[o*6 +: 5])] = 1'b1;
    return r;
  endfunction

  function automatic logic [NO-1:0] exp_en(input logic [CW-1:0] lv);
    logic [NO-1:0] r;
    for (int o = 0; o < NO; o++) r[o] = lv[o*6+5];
    return r;
  endfunction

  task automatic chk(input string req, input logic [NO*NI-1:0] act,
                     input logic [NO*NI-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    chk(req, NO*NI'(out_en), NO*NI'(exp_en(m_live)));
    chk(req, xpt_sel, exp_sel(m_live));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic par_write(input int addr, input logic [5:0] d, input logic junk_ser);
    ser_mode = 1'b0; wr_en = 1'b1; par_addr = 5'(addr); par_data = d;
    ser_in = junk_ser;                       // R10: ignored in parallel mode
    step();
    wr_en = 1'b0;
    m_stage[addr*6 +: 6] = d;
  endtask

  task automatic transfer();
    upd_n = 1'b0;
    step();
    upd_n = 1'b1;
    m_live = m_stage;
  endtask

  task automatic shift_bit(input logic b);
    ser_mode = 1'b1; wr_en = 1'b1; ser_in = b;
    par_addr = 5'($urandom); par_data = 6'($urandom); // R10: ignored in serial mode
    step();
    m_stage = {m_stage[CW-2:0], b};
  endtask

  // Builds a chain image from entries: output 31 first, MSB first.
  task automatic serial_load(input logic [CW-1:0] img, input bit check_replay);
    for (int k = CW - 1; k >= 0; k--) begin
      if (check_replay) chk("R5 ser_out replay", NO*NI'(ser_out), NO*NI'(m_stage[CW-1]));
      shift_bit(img[k]);
    end
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    chk("R1 reset outputs", xpt_sel, '0);
    chk("R1 reset enables", NO*NI'(out_en), '0);
    chk("R1 reset ser_out", NO*NI'(ser_out), '0);
    step();
    rst_n = 1'b1;
    step();
    transfer();
    chk_outputs("R1 empty after release");
  endtask

  task automatic t_parallel();
    par_write(0, 6'h23, 1'b1);
    par_write(7, 6'h3F, 1'b0);
    par_write(31, 6'h20, 1'b1);
    par_write(12, 6'h05, 1'b1);   // enable clear, nonzero index: R2
    chk("R8 no transfer yet", xpt_sel, '0);
    transfer();
    chk_outputs("R2 R3 R7 parallel pattern");
    par_write(7, 6'h21, 1'b0);
    transfer();
    chk_outputs("R7 neighbours untouched");
  endtask

  task automatic t_no_write();
    ser_mode = 1'b0; wr_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      par_addr = 5'(k); par_data = 6'h3A; ser_in = 1'b1; step();
    end
    ser_mode = 1'b1;
    for (int k = 0; k < 4; k++) begin ser_in = k[0]; step(); end
    chk("R6 ser_out held", NO*NI'(ser_out), NO*NI'(m_stage[CW-1]));
    transfer();
    chk_outputs("R6 stage unchanged");
  endtask

  task automatic t_serial();
    logic [CW-1:0] img1, img2;
    for (int o = 0; o < NO; o++) begin
      img1[o*6 +: 6] = {o[0] | o[2], 5'(31 - o)};
      img2[o*6 +: 6] = {1'b1, 5'((o * 7 + 3) % 32)};
    end
    img1[5:0] = 6'h2A;   // output 0: last six bits sent
    serial_load(img1, 1'b0);
    chk("R8 serial staged only", NO*NI'(out_en), NO*NI'(exp_en(m_live)));
    chk("R4 chain end is first bit", NO*NI'(ser_out), NO*NI'(img1[CW-1]));
    transfer();
    chk("R4 image placement", NO*NI'(m_live == img1), NO*NI'(1'b1));
    chk_outputs("R4 serial decode");
    serial_load(img2, 1'b1);
    transfer();
    chk_outputs("R5 second pass decode");
  endtask

  task automatic t_transparent();
    upd_n = 1'b0;
    step();
    m_live = m_stage;
    ser_mode = 1'b0; wr_en = 1'b1; par_addr = 5'd9; par_data = 6'h31;
    step();                      // live takes pre-edge stage
    wr_en = 1'b0;
    chk_outputs("R9 lag one cycle");
    m_stage[9*6 +: 6] = 6'h31;
    step();
    m_live = m_stage;
    chk_outputs("R9 follows stage");
    upd_n = 1'b1;
  endtask

  task automatic t_reset_mid();
    par_write(3, 6'h2E, 1'b0);
    transfer();
    chk_outputs("R3 before reset");
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async clear", xpt_sel, '0);
    chk("R1 async enables", NO*NI'(out_en), '0);
    m_stage = '0; m_live = '0;
    step();
    rst_n = 1'b1;
    step();
    transfer();
    chk_outputs("R1 cleared stage");
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_parallel();
    t_no_write();
    t_serial();
    t_transparent();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule